// File: doc/BRIEF.md
# TDM Network-Mode Serial Transmitter

This block is the transmit half of a synchronous serial port that runs in time-division-multiplexed network mode. The bit clock runs all the time. The block's clock is that bit clock, so one clock cycle carries one bit. Counters keep track of the bit position within a slot and the slot position within a frame. The block generates a one-bit-wide frame sync at the first bit of slot 0.

Software decides what happens in each slot, one slot ahead.
- Writing a word to the data register makes the next slot transmit that word, most significant bit first, with the output enable high.
- Writing the skip register makes the next slot silent, with the output enable low for the whole slot.
- Both writes clear the empty flag.
- At every slot start that consumes a pending entry, the empty flag is set again. An interrupt request follows the empty flag when interrupts are enabled.
- If nothing was written by the time a slot ends, the transmitter records an underrun and the following slot stays silent.

Top module: `tdm_net_tx`

## Requirements
- R1: `slots_m1` (values 1 to 31) selects `slots_m1 + 1` slots per frame. The slot counter wraps to slot 0 after the last slot.
- R2: `fsync` is high for exactly one cycle, during bit 0 of slot 0. A frame lasts word length times slot count cycles.
- R3: The transmitter sends only while both `port_en` and `tx_en` are high. `tx_en` is sampled only in the last bit of a slot, so raising it partway through a slot or frame has no effect before the next slot boundary.
- R4: `wr_data` stores `wdata` and clears `tx_empty`. The next enabled slot drives the word on `sd_out` MSB first, one bit per cycle, with `sd_oe` high for every bit of the slot. The word occupies the low bits of `wdata`. The `wl_sel` encodings are 0 = 8, 1 = 10, 2 = 12 and 3 = 16 bits.
- R5: `wr_skip` clears `tx_empty`. The next enabled slot keeps `sd_oe` low for all of its bits.
- R6: When an enabled slot boundary consumes a pending data or skip entry, `tx_empty` becomes 1 at the start of the new slot.
- R7: `tx_irq` is high exactly when `tx_empty` and `tie` are both high.
- R8: If `tx_en` is high at a slot boundary and nothing is pending, `underrun` becomes 1 and the new slot is silent. A write in the boundary cycle itself counts as late. `underrun` stays set until a `clr_uf` pulse clears it.
- R9: Dropping `tx_en` while a word is shifting lets that word finish. Later slots are silent and a pending entry is kept.
- R10: After reset, `sd_oe`, `fsync` and `underrun` are 0 and `tx_empty` is 1.
- R11: While `port_en` is low, the counters are held at bit 0 of slot 0 and `sd_oe` is low. When it rises, the frame starts at once with `fsync`, and that first slot is silent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | bit clock |
| rst_n | input | 1 | active-low reset |
| port_en | input | 1 | serial port enable |
| tx_en | input | 1 | transmit enable |
| tie | input | 1 | transmit interrupt enable |
| wl_sel | input | 2 | word length code |
| slots_m1 | input | SLOT_W | slots per frame minus one |
| wr_data | input | 1 | data register write strobe |
| wdata | input | MAX_WL | word to send |
| wr_skip | input | 1 | skip register write strobe |
| clr_uf | input | 1 | underrun clear strobe |
| sd_out | output | 1 | serial data |
| sd_oe | output | 1 | serial data drive enable |
| fsync | output | 1 | generated frame sync |
| tx_empty | output | 1 | nothing pending for the next slot |
| tx_irq | output | 1 | transmit interrupt request |
| underrun | output | 1 | sticky underrun error |

## Verification
The hardest cases to reach depend on timing within a slot: `tx_en` dropping while a word is still shifting, and `tx_en` rising partway through a frame while an entry is already pending. The driver acts at a fixed bit of every slot, using a bit and slot count it keeps itself. It queues one expected outcome per slot for the slot that follows. The monitor then checks every bit of each slot against that queue, so a word cut short or a slot started early shows up as a mismatch. Runs with a 2-slot frame and a 32-slot frame cover the wrap of the slot counter and the frame sync period.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;

   typedef enum logic [1:0] {
      PEND_NONE = 2'd0,
      PEND_DATA = 2'd1,
      PEND_SKIP = 2'd2
   } pend_e;

   function automatic int wl_decode(input logic [1:0] sel);
      case (sel)
         2'd0:    return 8;
         2'd1:    return 10;
         2'd2:    return 12;
         default: return 16;
      endcase
   endfunction

endpackage

// File: rtl/tdm_slot_timer.sv
module tdm_slot_timer #(
   parameter int SLOT_W = 5,
   parameter int BIT_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              port_en,
   input  logic [BIT_W-1:0]  last_bit,
   input  logic [SLOT_W-1:0] last_slot,
   output logic              slot_end,
   output logic              fsync
);

   logic [BIT_W-1:0]  bit_cnt;
   logic [SLOT_W-1:0] slot_cnt;

   assign slot_end = port_en && (bit_cnt == last_bit);
   assign fsync    = port_en && (bit_cnt == '0) && (slot_cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt  <= '0;
         slot_cnt <= '0;
      end else if (!port_en) begin
         bit_cnt  <= '0;
         slot_cnt <= '0;
      end else if (slot_end) begin
         bit_cnt  <= '0;
         slot_cnt <= (slot_cnt == last_slot) ? '0 : slot_cnt + 1'b1;
      end else begin
         bit_cnt  <= bit_cnt + 1'b1;
      end
   end

   // R2: the end of the last slot is followed by frame sync
   assert_wrap_fsync_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_end && slot_cnt == last_slot) |=> (fsync || !port_en));

   // R2: frame sync lasts a single bit
   assert_fsync_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      fsync |=> !fsync);

endmodule

// File: rtl/tdm_tx_holding.sv
module tdm_tx_holding
   import tdm_tx_pkg::*;
#(
   parameter int MAX_WL = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  logic              wr_data,
   input  logic [MAX_WL-1:0] wdata,
   input  logic              wr_skip,
   input  logic              clr_uf,
   output pend_e             pend,
   output logic [MAX_WL-1:0] hold_word,
   output logic              empty,
   output logic              underrun
);

   pend_e pend_nx;
   logic  uf_nx;
   logic  starve;

   assign starve = take && (pend == PEND_NONE);
   assign empty  = (pend == PEND_NONE);

   always_comb begin
      pend_nx = pend;
      uf_nx   = underrun;
      if (take) pend_nx = PEND_NONE;
      if (clr_uf) uf_nx = 1'b0;
      if (starve) uf_nx = 1'b1;
      if (wr_data)      pend_nx = PEND_DATA;
      else if (wr_skip) pend_nx = PEND_SKIP;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend      <= PEND_NONE;
         hold_word <= '0;
         underrun  <= 1'b0;
      end else begin
         pend     <= pend_nx;
         underrun <= uf_nx;
         if (wr_data) hold_word <= wdata;
      end
   end

   assert_data_fills_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_data |=> !empty);

   assert_skip_fills_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_skip |=> !empty);

   assert_take_drains_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !wr_data && !wr_skip) |=> empty);

   assert_uf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (underrun && !clr_uf) |=> underrun);

   assert_uf_only_on_starve_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(underrun) |-> $past(take));

endmodule

// File: rtl/tdm_tx_shifter.sv
module tdm_tx_shifter #(
   parameter int MAX_WL = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              port_en,
   input  logic              slot_end,
   input  logic              load,
   input  logic [MAX_WL-1:0] word,
   output logic              sd_out,
   output logic              sd_oe
);

   logic              active;
   logic [MAX_WL-1:0] sr;

   assign sd_oe  = active;
   assign sd_out = active & sr[MAX_WL-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         sr     <= '0;
      end else if (!port_en) begin
         active <= 1'b0;
      end else if (slot_end) begin
         active <= load;
         if (load) sr <= word;
      end else begin
         sr <= {sr[MAX_WL-2:0], 1'b0};
      end
   end

   // R9: drive state changes only at a slot boundary
   assert_oe_hold_in_slot_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (port_en && !slot_end) |=> (!port_en || $stable(sd_oe)));

   // R3: driving starts only after a boundary
   assert_start_on_boundary_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sd_oe) |-> $past(slot_end));

   // R11: no drive while the port is off
   assert_off_silent_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !port_en |=> (!sd_oe || port_en));

endmodule

// File: rtl/tdm_net_tx.sv
module tdm_net_tx
   import tdm_tx_pkg::*;
#(
   parameter int SLOT_W = 5,
   parameter int MAX_WL = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              port_en,
   input  logic              tx_en,
   input  logic              tie,
   input  logic [1:0]        wl_sel,
   input  logic [SLOT_W-1:0] slots_m1,
   input  logic              wr_data,
   input  logic [MAX_WL-1:0] wdata,
   input  logic              wr_skip,
   input  logic              clr_uf,
   output logic              sd_out,
   output logic              sd_oe,
   output logic              fsync,
   output logic              tx_empty,
   output logic              tx_irq,
   output logic              underrun
);

   localparam int BIT_W = $clog2(MAX_WL);

   generate
      if (MAX_WL != 16) begin : g_bad_wl
         $error("tdm_net_tx: MAX_WL must be 16 to hold the widest word code");
      end
      if (SLOT_W != 5) begin : g_bad_slot
         $error("tdm_net_tx: SLOT_W must be 5 for 2 to 32 slots");
      end
   endgenerate

   logic [BIT_W:0]    wl_len;
   logic [BIT_W-1:0]  last_bit;
   logic              slot_end;
   logic              take;
   logic              load;
   pend_e             pend;
   logic [MAX_WL-1:0] hold_word;
   logic [MAX_WL-1:0] aligned;

   assign wl_len   = (BIT_W+1)'(wl_decode(wl_sel));
   assign last_bit = BIT_W'(wl_len - 1'b1);
   assign take     = slot_end && tx_en;
   assign load     = take && (pend == PEND_DATA);
   assign aligned  = hold_word << (MAX_WL - int'(wl_len));
   assign tx_irq   = tx_empty && tie;

   tdm_slot_timer #(.SLOT_W(SLOT_W), .BIT_W(BIT_W)) timer_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .port_en   (port_en),
      .last_bit  (last_bit),
      .last_slot (slots_m1),
      .slot_end  (slot_end),
      .fsync     (fsync)
   );

   tdm_tx_holding #(.MAX_WL(MAX_WL)) hold_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .take      (take),
      .wr_data   (wr_data),
      .wdata     (wdata),
      .wr_skip   (wr_skip),
      .clr_uf    (clr_uf),
      .pend      (pend),
      .hold_word (hold_word),
      .empty     (tx_empty),
      .underrun  (underrun)
   );

   tdm_tx_shifter #(.MAX_WL(MAX_WL)) shift_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .port_en  (port_en),
      .slot_end (slot_end),
      .load     (load),
      .word     (aligned),
      .sd_out   (sd_out),
      .sd_oe    (sd_oe)
   );

   // R7: a request is only raised with interrupts enabled
   assert_irq_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_irq && $stable(tie)) |-> tie);

endmodule

// File: tb/tdm_net_tx_tb.sv
module tdm_net_tx_tb_top;

   typedef struct {
      bit          oe;
      logic [15:0] word;
      string       req;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        port_en = 1'b0, tx_en = 1'b0, tie = 1'b0;
   logic [1:0]  wl_sel = 2'd0;
   logic [4:0]  slots_m1 = 5'd3;
   logic        wr_data = 1'b0, wr_skip = 1'b0, clr_uf = 1'b0;
   logic [15:0] wdata = '0;
   logic        sd_out, sd_oe, fsync, tx_empty, tx_irq, underrun;

   int checks = 0, errors = 0;
   bit done = 0;
   exp_t q[$];
   int mbit = 0, mslot = 0, cur_wl = 8, cur_slots = 4;
   bit fs_ok = 1, oe_all = 1, oe_any = 0;
   logic [15:0] obs = '0;
   int bpend = 0;
   logic [15:0] bword = '0;
   bit exp_uf = 0;

   always #2.5 clk = ~clk;

   tdm_net_tx dut_i (
      .clk(clk), .rst_n(rst_n), .port_en(port_en), .tx_en(tx_en), .tie(tie),
      .wl_sel(wl_sel), .slots_m1(slots_m1), .wr_data(wr_data), .wdata(wdata),
      .wr_skip(wr_skip), .clr_uf(clr_uf), .sd_out(sd_out), .sd_oe(sd_oe),
      .fsync(fsync), .tx_empty(tx_empty), .tx_irq(tx_irq), .underrun(underrun)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // monitor: compares every slot with the queued expectation
   always @(negedge clk) begin
      if (!port_en) begin
         mbit = 0;
         mslot = 0;
      end else begin
         if (fsync !== (mbit == 0 && mslot == 0)) fs_ok = 0;
         if (mbit == 0) begin
            oe_all = 1;
            oe_any = 0;
            obs = '0;
         end
         oe_all = oe_all & (sd_oe === 1'b1);
         oe_any = oe_any | (sd_oe !== 1'b0);
         obs = {obs[14:0], sd_out};
         if (mbit == cur_wl - 1) begin
            if (q.size() == 0) begin
               chk(0, "R4 slot without expectation", 32'(mslot), 0);
            end else begin
               exp_t e;
               e = q.pop_front();
               if (e.oe)
                  chk(oe_all && obs == e.word, e.req, {15'd0, oe_all, obs}, {16'd1, e.word});
               else
                  chk(!oe_any, e.req, 32'(oe_any), 0);
            end
            if (mslot == cur_slots - 1) begin
               chk(fs_ok, "R1 R2 frame sync position", 32'(fs_ok), 1);
               fs_ok = 1;
            end
            mbit = 0;
            mslot = (mslot == cur_slots - 1) ? 0 : mslot + 1;
         end else begin
            mbit++;
         end
      end
   end

   // one call per slot; acts at bit 2 and queues the next slot's outcome
   task automatic step(input int act, input logic [15:0] d, input bit te, input bit clr);
      logic [15:0] mask;
      exp_t e;
      mask = 16'((32'd1 << cur_wl) - 1);
      do begin @(negedge clk); #1; end while (mbit != 2);
      chk(tx_empty == (bpend == 0), "R6 empty flag", 32'(tx_empty), 32'(bpend == 0));
      chk(tx_irq == ((bpend == 0) && tie), "R7 interrupt", 32'(tx_irq), 32'((bpend == 0) && tie));
      chk(underrun == exp_uf, "R8 underrun flag", 32'(underrun), 32'(exp_uf));
      @(posedge clk); #1;
      tx_en = te;
      clr_uf = clr;
      if (act == 1) begin wr_data = 1; wdata = d; end
      if (act == 2) wr_skip = 1;
      @(posedge clk); #1;
      wr_data = 0; wr_skip = 0; clr_uf = 0;
      if (clr) exp_uf = 0;
      if (act == 1) begin bpend = 1; bword = d; end
      if (act == 2) bpend = 2;
      if (act != 0) begin
         @(negedge clk);
         chk(!tx_empty, act == 1 ? "R4 write clears empty" : "R5 skip clears empty", 32'(tx_empty), 0);
      end
      if (te) begin
         case (bpend)
            1: begin e.oe = 1; e.word = bword & mask; e.req = "R4 word sent"; end
            2: begin e.oe = 0; e.word = '0; e.req = "R5 skipped slot"; end
            default: begin e.oe = 0; e.word = '0; e.req = "R8 underrun slot silent"; exp_uf = 1; end
         endcase
         bpend = 0;
      end else begin
         e.oe = 0; e.word = '0; e.req = "R3 R9 disabled slot silent";
      end
      q.push_back(e);
   endtask

   task automatic start_run(input logic [1:0] code, input logic [4:0] sm1);
      exp_t e;
      wl_sel = code;
      slots_m1 = sm1;
      cur_wl = (code == 0) ? 8 : (code == 1) ? 10 : (code == 2) ? 12 : 16;
      cur_slots = int'(sm1) + 1;
      e.oe = 0; e.word = '0; e.req = "R11 first slot silent";
      q.push_back(e);
      @(posedge clk); #1;
      port_en = 1;
      @(negedge clk);
      chk(fsync == 1'b1, "R11 frame starts with sync", 32'(fsync), 1);
   endtask

   task automatic stop_run();
      do begin @(negedge clk); #1; end while (q.size() != 0);
      @(posedge clk); #1;
      port_en = 0;
      repeat (2) @(negedge clk);
      chk(sd_oe == 1'b0 && fsync == 1'b0, "R11 port off silent", {sd_oe, fsync}, 0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      @(negedge clk);
      chk(sd_oe == 0, "R10 oe after reset", 32'(sd_oe), 0);
      chk(fsync == 0, "R10 fsync after reset", 32'(fsync), 0);
      chk(tx_empty == 1, "R10 empty after reset", 32'(tx_empty), 1);
      chk(underrun == 0 && tx_irq == 0, "R10 flags after reset", {underrun, tx_irq}, 0);

      // run A: 8-bit words, 4 slots
      tie = 1;
      start_run(2'd0, 5'd3);
      step(1, 16'h00A5, 0, 0);   // R3 pending but disabled
      step(0, 16'h0, 1, 0);      // R3 enable mid-frame, sent next slot
      step(1, 16'h003C, 1, 0);
      step(2, 16'h0, 1, 0);      // R5
      step(1, 16'h0081, 1, 0);
      step(0, 16'h0, 1, 0);      // R8 starve
      step(1, 16'h007E, 1, 1);   // R8 clear
      step(1, 16'h00C3, 0, 0);   // R9 disable while shifting
      step(0, 16'h0, 0, 0);
      step(0, 16'h0, 1, 0);
      step(0, 16'h0, 0, 0);
      stop_run();

      // run B: 16-bit words, 2 slots, interrupts off
      tie = 0;
      start_run(2'd3, 5'd1);
      step(1, 16'hBEEF, 1, 0);
      step(1, 16'h1234, 1, 0);
      step(2, 16'h0, 1, 0);
      step(1, 16'h8001, 1, 0);
      step(0, 16'h0, 0, 0);
      stop_run();

      // run C: 10-bit words, 32 slots
      tie = 1;
      start_run(2'd1, 5'd31);
      for (int i = 0; i < 34; i++) begin
         if (i % 5 == 4) step(2, 16'h0, 1, 0);
         else step(1, 16'(i * 37 + 16'h155), 1, 0);
      end
      step(0, 16'h0, 0, 0);
      stop_run();

      // run D: 12-bit words, 3 slots
      start_run(2'd2, 5'd2);
      step(1, 16'h0ABC, 1, 0);
      step(1, 16'h0F0F, 1, 0);
      step(0, 16'h0, 0, 0);
      stop_run();

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule